// File: doc/BRIEF.md
# Floating-Point Class Decoder

This block inspects packed floating-point words of any exponent and fraction width and sorts each value into one of ten categories. A word is laid out with the sign in the top bit, the biased exponent below it and the fraction in the low bits. For each value the decoder gives two forms of the same answer: a 4-bit class code and a one-hot vector of ten bits. From the category it derives three flags: not-a-number, finite and negative. It takes two operands, A and B, through identical, independent paths. It also raises an unordered flag when either operand is a NaN.

The block is purely combinational. It suits a floating-point pipeline that needs a category before it picks a special-case path, and a compare unit that needs the unordered result. The parameter `DENORM_EN` picks how tiny values are reported. When it is set, denormal values keep their own categories. When it is clear, every denormal pattern is reported as a zero of the same sign, which matches a datapath that flushes such values.

Top module: `fp_class_decoder`

## Requirements
- R1: Each one-hot class output has exactly one bit set, and the set bit's index equals the class code of the same operand.
- R2: Class codes are 0 signaling NaN, 1 quiet NaN, 2 negative infinity, 3 negative normal, 4 negative denormal, 5 negative zero, 6 positive zero, 7 positive denormal, 8 positive normal and 9 positive infinity. No value outside 0..9 is produced.
- R3: An exponent of all ones with a zero fraction gives code 2 when the sign bit (the top bit) is 1, and code 9 when it is 0.
- R4: An exponent of all ones with a nonzero fraction is a NaN. It gives code 0 (signaling) when the fraction's top bit is 1 and code 1 (quiet) otherwise, whatever the sign.
- R5: An exponent of all zeros with a zero fraction gives code 5 when the sign is 1 and code 6 when it is 0.
- R6: An exponent of all zeros with a nonzero fraction gives code 4 or 7 (by sign) when `DENORM_EN` is 1. When `DENORM_EN` is 0 it gives code 5 or 6 (by sign).
- R7: Any other exponent gives code 3 when the sign is 1 and code 8 when it is 0.
- R8: The NaN flag is 1 exactly for codes 0 and 1.
- R9: The finite flag is 0 exactly for codes 2 and 9, and is 1 for every other code, NaNs included.
- R10: The negative flag is 1 exactly for codes 2 to 5, so it is never set for a NaN.
- R11: `unordered_o` is 1 when either operand has code 0 or 1.
- R12: Operand B is classified by the same rules as operand A, independently of A's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_word_i | input | EXP_W+FRAC_W+1 | Operand A, packed as sign, exponent, fraction |
| b_word_i | input | EXP_W+FRAC_W+1 | Operand B, same packing |
| a_class_o | output | 10 | One-hot category of A |
| a_code_o | output | 4 | Class code of A |
| a_nan_o | output | 1 | A is a NaN of either kind |
| a_finite_o | output | 1 | A is not an infinity |
| a_neg_o | output | 1 | A is a negative non-NaN value |
| b_class_o | output | 10 | One-hot category of B |
| b_code_o | output | 4 | Class code of B |
| b_nan_o | output | 1 | B is a NaN of either kind |
| b_finite_o | output | 1 | B is not an infinity |
| b_neg_o | output | 1 | B is a negative non-NaN value |
| unordered_o | output | 1 | A or B is a NaN |

## Verification
The bench targets the boundaries between categories, where a wrong decoder goes astray.

- **NaN kind.** NaNs with the fraction's top bit set and clear, and with both signs, catch a decoder that uses the opposite signaling convention or lets the sign steer the NaN kind.
- **Denormal edges.** The smallest and largest denormal patterns and the smallest normal catch an off-by-one on the exponent tests and a denormal shown as normal. A second instance with denormals disabled must report those same patterns as signed zeros.
- **Flags.** Negative NaNs and infinities expose a negative flag that just copies the sign bit, and a finite flag that drops out for NaNs.
- **Mixed pairs.** Operand pairs in which only B is a NaN expose an unordered flag that looks at A alone.

// File: rtl/fp_class_pkg.sv
package fp_class_pkg;

   // number of categories and width of the encoded class
   localparam int unsigned FPC_NUM    = 10;
   localparam int unsigned FPC_CODE_W = 4;

   // category numbering; the one-hot output follows this order
   typedef enum logic [FPC_CODE_W-1:0] {
      FPC_SNAN     = 4'd0,
      FPC_QNAN     = 4'd1,
      FPC_NEG_INF  = 4'd2,
      FPC_NEG_NORM = 4'd3,
      FPC_NEG_SUB  = 4'd4,
      FPC_NEG_ZERO = 4'd5,
      FPC_POS_ZERO = 4'd6,
      FPC_POS_SUB  = 4'd7,
      FPC_POS_NORM = 4'd8,
      FPC_POS_INF  = 4'd9
   } fpc_code_e;

   // pick the sign-dependent member of a category pair
   function automatic fpc_code_e fpc_by_sign(input logic neg,
                                             input fpc_code_e neg_code,
                                             input fpc_code_e pos_code);
      return neg ? neg_code : pos_code;
   endfunction

endpackage

// File: rtl/fp_field_split.sv
// Reduces one packed word to the handful of facts the classifier needs.
module fp_field_split #(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] word_i,
   output logic                  sign_o,
   output logic                  exp_ones_o,
   output logic                  exp_zero_o,
   output logic                  frac_zero_o,
   output logic                  frac_top_o
);

   localparam int unsigned WORD_W   = EXP_W + FRAC_W + 1;
   localparam int unsigned SIGN_POS = WORD_W - 1;

   logic [EXP_W-1:0]  exp_field;
   logic [FRAC_W-1:0] frac_field;

   assign exp_field  = word_i[FRAC_W +: EXP_W];
   assign frac_field = word_i[FRAC_W-1:0];

   assign sign_o      = word_i[SIGN_POS];
   assign exp_ones_o  = &exp_field;
   assign exp_zero_o  = ~|exp_field;
   assign frac_zero_o = ~|frac_field;
   assign frac_top_o  = frac_field[FRAC_W-1];

endmodule

// File: rtl/fp_class_resolve.sv
// Turns the field facts into a class code; DENORM_EN picks how tiny values are treated.
module fp_class_resolve
   import fp_class_pkg::*;
#(
   parameter bit DENORM_EN = 1'b1
) (
   input  logic      sign_i,
   input  logic      exp_ones_i,
   input  logic      exp_zero_i,
   input  logic      frac_zero_i,
   input  logic      frac_top_i,
   output fpc_code_e code_o
);

   logic is_zero_cls;
   logic is_sub_cls;

   generate
      if (DENORM_EN) begin : g_keep_sub
         logic sub_pattern;
         assign sub_pattern = exp_zero_i & ~frac_zero_i;
         assign is_zero_cls = exp_zero_i & frac_zero_i;
         assign is_sub_cls  = sub_pattern;
      end else begin : g_flush_sub
         // every pattern with a zero exponent reads as a signed zero
         assign is_zero_cls = exp_zero_i;
         assign is_sub_cls  = 1'b0;
      end
   endgenerate

   always_comb begin
      if (exp_ones_i) begin
         if (frac_zero_i)
            code_o = fpc_by_sign(sign_i, FPC_NEG_INF, FPC_POS_INF);
         else
            code_o = frac_top_i ? FPC_SNAN : FPC_QNAN;
      end else if (is_zero_cls) begin
         code_o = fpc_by_sign(sign_i, FPC_NEG_ZERO, FPC_POS_ZERO);
      end else if (is_sub_cls) begin
         code_o = fpc_by_sign(sign_i, FPC_NEG_SUB, FPC_POS_SUB);
      end else begin
         code_o = fpc_by_sign(sign_i, FPC_NEG_NORM, FPC_POS_NORM);
      end
   end

endmodule

// File: rtl/fp_code_expand.sv
// Expands a class code into the one-hot vector and the derived flags.
module fp_code_expand
   import fp_class_pkg::*;
(
   input  fpc_code_e            code_i,
   output logic [FPC_NUM-1:0]   onehot_o,
   output logic                 nan_o,
   output logic                 finite_o,
   output logic                 neg_o
);

   logic [FPC_CODE_W-1:0] code_raw;
   assign code_raw = code_i;

   generate
      for (genvar k = 0; k < FPC_NUM; k++) begin : g_bit
         assign onehot_o[k] = (code_raw == FPC_CODE_W'(k));
      end
   endgenerate

   assign nan_o    = onehot_o[FPC_SNAN] | onehot_o[FPC_QNAN];
   assign finite_o = ~(onehot_o[FPC_NEG_INF] | onehot_o[FPC_POS_INF]);
   assign neg_o    = onehot_o[FPC_NEG_INF] | onehot_o[FPC_NEG_NORM] |
                     onehot_o[FPC_NEG_SUB] | onehot_o[FPC_NEG_ZERO];

endmodule

// File: rtl/fp_class_decoder.sv
module fp_class_decoder
   import fp_class_pkg::*;
#(
   parameter int unsigned EXP_W     = 8,
   parameter int unsigned FRAC_W    = 23,
   parameter bit          DENORM_EN = 1'b1
) (
   input  logic [EXP_W+FRAC_W:0] a_word_i,
   input  logic [EXP_W+FRAC_W:0] b_word_i,
   output logic [9:0]            a_class_o,
   output logic [3:0]            a_code_o,
   output logic                  a_nan_o,
   output logic                  a_finite_o,
   output logic                  a_neg_o,
   output logic [9:0]            b_class_o,
   output logic [3:0]            b_code_o,
   output logic                  b_nan_o,
   output logic                  b_finite_o,
   output logic                  b_neg_o,
   output logic                  unordered_o
);

   localparam int unsigned WORD_W = EXP_W + FRAC_W + 1;
   localparam int unsigned N_OPS  = 2;

   // elaboration-time parameter checks
   generate
      if (EXP_W < 3) begin : g_bad_exp
         $error("fp_class_decoder: EXP_W must be at least 3");
      end
      if (FRAC_W < 3) begin : g_bad_frac
         $error("fp_class_decoder: FRAC_W must be at least 3");
      end
      if (FPC_NUM != 10 || FPC_CODE_W != 4) begin : g_bad_pkg
         $error("fp_class_decoder: class table does not match port widths");
      end
   endgenerate

   logic [WORD_W-1:0]  op_word   [N_OPS];
   fpc_code_e          op_code   [N_OPS];
   logic [FPC_NUM-1:0] op_onehot [N_OPS];
   logic [N_OPS-1:0]   op_nan;
   logic [N_OPS-1:0]   op_finite;
   logic [N_OPS-1:0]   op_neg;

   assign op_word[0] = a_word_i;
   assign op_word[1] = b_word_i;

   generate
      for (genvar i = 0; i < N_OPS; i++) begin : g_op
         logic sgn, e_ones, e_zero, f_zero, f_top;

         fp_field_split #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
         ) u_split (
            .word_i      (op_word[i]),
            .sign_o      (sgn),
            .exp_ones_o  (e_ones),
            .exp_zero_o  (e_zero),
            .frac_zero_o (f_zero),
            .frac_top_o  (f_top)
         );

         fp_class_resolve #(
            .DENORM_EN (DENORM_EN)
         ) u_resolve (
            .sign_i      (sgn),
            .exp_ones_i  (e_ones),
            .exp_zero_i  (e_zero),
            .frac_zero_i (f_zero),
            .frac_top_i  (f_top),
            .code_o      (op_code[i])
         );

         fp_code_expand u_expand (
            .code_i   (op_code[i]),
            .onehot_o (op_onehot[i]),
            .nan_o    (op_nan[i]),
            .finite_o (op_finite[i]),
            .neg_o    (op_neg[i])
         );
      end
   endgenerate

   assign a_class_o  = op_onehot[0];
   assign a_code_o   = op_code[0];
   assign a_nan_o    = op_nan[0];
   assign a_finite_o = op_finite[0];
   assign a_neg_o    = op_neg[0];

   assign b_class_o  = op_onehot[1];
   assign b_code_o   = op_code[1];
   assign b_nan_o    = op_nan[1];
   assign b_finite_o = op_finite[1];
   assign b_neg_o    = op_neg[1];

   assign unordered_o = |op_nan;

endmodule

// File: rtl/fp_class_decoder_chk.sv
module fp_class_decoder_chk #(
   parameter int unsigned EXP_W     = 8,
   parameter int unsigned FRAC_W    = 23,
   parameter bit          DENORM_EN = 1'b1
) (
   input logic [EXP_W+FRAC_W:0] a_word_i,
   input logic [EXP_W+FRAC_W:0] b_word_i,
   input logic [9:0]            a_class_o,
   input logic [3:0]            a_code_o,
   input logic                  a_nan_o,
   input logic                  a_finite_o,
   input logic                  a_neg_o,
   input logic [9:0]            b_class_o,
   input logic [3:0]            b_code_o,
   input logic                  b_nan_o,
   input logic                  b_finite_o,
   input logic                  b_neg_o,
   input logic                  unordered_o
);

   localparam int unsigned TOP = EXP_W + FRAC_W;

   logic a_eones, a_ezero, a_fzero, a_sign;
   assign a_sign  = a_word_i[TOP];
   assign a_eones = &a_word_i[FRAC_W +: EXP_W];
   assign a_ezero = ~|a_word_i[FRAC_W +: EXP_W];
   assign a_fzero = ~|a_word_i[FRAC_W-1:0];

   always_comb begin
      // R1 / R2: single bit set, at the index of the code, code in range
      assert_onehot_R1: assert ($countones(a_class_o) == 1 && $countones(b_class_o) == 1)
         else $error("one-hot output does not have exactly one bit");
      assert_code_match_R2: assert (a_code_o <= 4'd9 && a_class_o[a_code_o] &&
                                    b_code_o <= 4'd9 && b_class_o[b_code_o])
         else $error("class code and one-hot disagree");
      // R3: infinities
      assert_inf_R3: assert (!(a_eones && a_fzero) || a_code_o == (a_sign ? 4'd2 : 4'd9))
         else $error("infinity misclassified");
      // R4: NaN kind from the fraction's top bit
      assert_nan_kind_R4: assert (!(a_eones && !a_fzero) ||
                                  a_code_o == (a_word_i[FRAC_W-1] ? 4'd0 : 4'd1))
         else $error("NaN kind wrong");
      // R5: signed zeros
      assert_zero_R5: assert (!(a_ezero && a_fzero) || a_code_o == (a_sign ? 4'd5 : 4'd6))
         else $error("zero misclassified");
      // R6: denormal patterns, depending on DENORM_EN
      assert_sub_R6: assert (!(a_ezero && !a_fzero) ||
                             a_code_o == (DENORM_EN ? (a_sign ? 4'd4 : 4'd7)
                                                    : (a_sign ? 4'd5 : 4'd6)))
         else $error("denormal misclassified");
      // R8 / R9 / R10: flags agree with the word itself
      assert_nan_flag_R8: assert (a_nan_o == (a_eones && !a_fzero))
         else $error("NaN flag wrong");
      assert_finite_R9: assert (a_finite_o == !(a_eones && a_fzero) &&
                                b_finite_o == (b_code_o != 4'd2 && b_code_o != 4'd9))
         else $error("finite flag wrong");
      assert_neg_R10: assert (a_neg_o == (a_sign && !a_nan_o) &&
                              b_neg_o == (b_word_i[TOP] && !b_nan_o))
         else $error("negative flag wrong");
      // R11: unordered follows the NaN flags of both operands
      assert_unordered_R11: assert (unordered_o == (a_nan_o || b_nan_o))
         else $error("unordered flag wrong");
   end

endmodule

bind fp_class_decoder fp_class_decoder_chk #(
   .EXP_W     (EXP_W),
   .FRAC_W    (FRAC_W),
   .DENORM_EN (DENORM_EN)
) u_chk (
   .a_word_i    (a_word_i),
   .b_word_i    (b_word_i),
   .a_class_o   (a_class_o),
   .a_code_o    (a_code_o),
   .a_nan_o     (a_nan_o),
   .a_finite_o  (a_finite_o),
   .a_neg_o     (a_neg_o),
   .b_class_o   (b_class_o),
   .b_code_o    (b_code_o),
   .b_nan_o     (b_nan_o),
   .b_finite_o  (b_finite_o),
   .b_neg_o     (b_neg_o),
   .unordered_o (unordered_o)
);

// File: tb/tb_fp_class_decoder.sv
`timescale 1ns/1ps
module tb_fp_class_decoder;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [31:0] a_w = '0, b_w = '0;
   logic [9:0]  a_cls, b_cls, f_cls, f_bcls;
   logic [3:0]  a_code, b_code, f_code, f_bcode;
   logic        a_nan, a_fin, a_neg, b_nan, b_fin, b_neg, unord;
   logic        f_anan, f_afin, f_aneg, f_bnan, f_bfin, f_bneg, f_unord;

   fp_class_decoder dut (
      .a_word_i(a_w), .b_word_i(b_w),
      .a_class_o(a_cls), .a_code_o(a_code), .a_nan_o(a_nan),
      .a_finite_o(a_fin), .a_neg_o(a_neg),
      .b_class_o(b_cls), .b_code_o(b_code), .b_nan_o(b_nan),
      .b_finite_o(b_fin), .b_neg_o(b_neg), .unordered_o(unord));

   fp_class_decoder #(.DENORM_EN(1'b0)) dut_flush (
      .a_word_i(a_w), .b_word_i(b_w),
      .a_class_o(f_cls), .a_code_o(f_code), .a_nan_o(f_anan),
      .a_finite_o(f_afin), .a_neg_o(f_aneg),
      .b_class_o(f_bcls), .b_code_o(f_bcode), .b_nan_o(f_bnan),
      .b_finite_o(f_bfin), .b_neg_o(f_bneg), .unordered_o(f_unord));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] a, b;
      int          ea, eb, ef;
      bit          nan, fin, neg, unord;
   } exp_t;
   exp_t sb_q[$];

   // reference classification written from the requirements (R2..R7)
   function automatic int ref_code(input logic [31:0] w, input bit keep_sub);
      logic       s  = w[31];
      logic [7:0] e  = w[30:23];
      logic [22:0] f = w[22:0];
      if (e == 8'hFF) begin
         if (f == 0) return s ? 2 : 9;               // R3
         return f[22] ? 0 : 1;                       // R4
      end
      if (e == 8'h00) begin
         if (f == 0) return s ? 5 : 6;               // R5
         if (keep_sub) return s ? 4 : 7;             // R6
         return s ? 5 : 6;                           // R6 flush
      end
      return s ? 3 : 8;                              // R7
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic drive(input logic [31:0] a, input logic [31:0] b);
      exp_t x;
      @(posedge clk);
      a_w = a;
      b_w = b;
      x.a = a; x.b = b;
      x.ea = ref_code(a, 1'b1);
      x.eb = ref_code(b, 1'b1);
      x.ef = ref_code(a, 1'b0);
      x.nan = (x.ea <= 1);
      x.fin = !(x.ea == 2 || x.ea == 9);
      x.neg = (x.ea >= 2 && x.ea <= 5);
      x.unord = x.nan || (x.eb <= 1);
      sb_q.push_back(x);
   endtask

   // monitor: compares one item per cycle, half a period after the inputs change
   always @(negedge clk) begin
      if (rst_n && sb_q.size() > 0) begin
         exp_t x;
         x = sb_q.pop_front();
         chk(a_code == 4'(x.ea), $sformatf("R2 code A word=%h", x.a), a_code, x.ea);
         chk(a_cls == (10'd1 << x.ea), "R1 one-hot A", a_cls, 10'd1 << x.ea);
         chk(a_nan == x.nan, "R8 NaN flag", a_nan, x.nan);
         chk(a_fin == x.fin, "R9 finite flag", a_fin, x.fin);
         chk(a_neg == x.neg, "R10 negative flag", a_neg, x.neg);
         chk(b_code == 4'(x.eb), $sformatf("R12 code B word=%h", x.b), b_code, x.eb);
         chk(b_cls == (10'd1 << x.eb), "R12 one-hot B", b_cls, 10'd1 << x.eb);
         chk(unord == x.unord, "R11 unordered", unord, x.unord);
         chk(f_code == 4'(x.ef), $sformatf("R6 flushed code word=%h", x.a), f_code, x.ef);
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: zero inputs read as positive zero (R5)
      chk(a_code == 4'd6, "R5 reset code", a_code, 6);
      chk(a_cls == 10'b0001000000, "R1 reset one-hot", a_cls, 10'b0001000000);
      rst_n = 1'b1;

      drive(32'h0000_0000, 32'h8000_0000);   // R5 zeros
      drive(32'h7F80_0000, 32'hFF80_0000);   // R3 infinities
      drive(32'hFF80_0000, 32'h3F80_0000);   // R3 R9 R10 negative infinity
      drive(32'h7FC0_0000, 32'h0000_0000);   // R4 signaling (top bit set)
      drive(32'h7F80_0001, 32'h7FC0_0000);   // R4 quiet, R11
      drive(32'hFF80_0001, 32'hFFC0_0000);   // R4 R10 negative-sign NaNs
      drive(32'hFFFF_FFFF, 32'h7F7F_FFFF);   // R4 all ones
      drive(32'h0000_0001, 32'h807F_FFFF);   // R6 smallest and largest denormal
      drive(32'h807F_FFFF, 32'h0040_0000);   // R6 negative denormal
      drive(32'h0080_0000, 32'h8080_0000);   // R7 smallest normal
      drive(32'h3F80_0000, 32'h7F80_0001);   // R7 normal, R11 B only NaN
      drive(32'hC049_0FDB, 32'h7F7F_FFFF);   // R7 negative normal, largest normal
      drive(32'h7F7F_FFFF, 32'hFF80_0000);   // R7 R12
      drive(32'h8000_0000, 32'h0000_0001);   // R5 R12

      while (sb_q.size() > 0) @(negedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule